// File: doc/BRIEF.md
# Multi-Lane Squared-Difference Stage with Write-Enable Gating

This block sits beside a vector processor's execute stage and applies one custom operation across several lanes at once. In every lane it takes an element from operand A and one from operand B, forms the difference A minus B, and squares it. Each lane runs a fixed-latency pipeline that may be deeper than the host's own execute path. The host never stalls: it presents a new issue every cycle it likes, qualified by `valid`.

Each lane's result leaves the block together with a write-enable. The pipeline holds the write-enables low while it fills, and raises one only in the cycle a real result reaches the output. The host can then write the destination without knowing how deep the pipeline is. A `start` pulse begins a new instruction and throws away any results still inside the pipeline from earlier issues. An element-size code selects 8, 16 or 32-bit arithmetic. An opcode picks between the squared difference and a plain copy of A.

The data path has no ready signal and applies no back-pressure. Every issue with `valid` high is accepted in that cycle, and its result is presented exactly `LATENCY` cycles later unless a `start` intervenes. The destination must therefore take a write in any cycle.

Top module: `sqd_lane_array`

## Requirements
- R1: With opcode equal to `SQDIFF_CODE` (default 4'h1) and size code 2'b10, each lane outputs (A − B)² modulo 2^32.
- R2: With size code 2'b00 only bits 7:0 of A and B are used. The lane outputs ((A − B)² mod 2^8) in bits 7:0 and zero in bits 31:8.
- R3: With size code 2'b01 only bits 15:0 of A and B are used. The lane outputs ((A − B)² mod 2^16) in bits 15:0 and zero in bits 31:16.
- R4: Size code 2'b11 behaves exactly as 2'b10.
- R5: Any opcode other than `SQDIFF_CODE` makes the lane output its A element unchanged, whatever the size code, with the same latency.
- R6: An issue sampled with `valid` high in cycle k raises the write-enables in cycle k+LATENCY and carries that issue's result. The write-enables are low in every cycle that has no such issue.
- R7: While reset is asserted, all write-enables and all result bits are zero.
- R8: A `start` sampled in cycle s cancels every issue from cycles before s that has not yet appeared at the output, so none of them raises a write-enable. An issue made in cycle s itself is kept.
- R9: All lanes share one latency, so the write-enable bits are always either all zero or all one.
- R10: Issues on consecutive cycles produce results on consecutive cycles in issue order, with no gap or stall.
- R11: While the write-enables are low, the result outputs hold the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | First issue of a new instruction; cancels results still in flight |
| valid | input | 1 | Operands on this cycle form an issue |
| opsize | input | 2 | Element size: 00 = 8-bit, 01 = 16-bit, 10 and 11 = 32-bit |
| opcode | input | OPC_W (4) | Operation select; `SQDIFF_CODE` selects the squared difference |
| a_vec | input | LANES*DATA_W (128) | Operand A, lane n in bits n*DATA_W upward |
| b_vec | input | LANES*DATA_W (128) | Operand B, same packing |
| res_vec | output | LANES*DATA_W (128) | Per-lane result, same packing |
| wr_en | output | LANES (4) | Per-lane destination write-enable |

## Verification
The bench first sends isolated issues, one per size code, with junk in the unused upper bits and with B larger than A. A wrong mask, a sign error or a missing truncation therefore shows up as a wrong lane value, not as a timing error. A pass-through opcode with non-trivial B shows whether the opcode decode is wired through. A long back-to-back run with random operands and mixed sizes separates a correct pipeline from one that drops, repeats or reorders results. Two `start` cases, one carrying an issue and one without, with older issues still in flight, show whether cancellation hits exactly the right items. Idle stretches between bursts show whether the outputs hold their last written value.

// File: rtl/sqd_pkg.sv
package sqd_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [1:0] {
    SZ_B8   = 2'b00,
    SZ_B16  = 2'b01,
    SZ_B32  = 2'b10,
    SZ_WIDE = 2'b11
  } elem_size_e;

endpackage

// File: rtl/sqd_elem_alu.sv
module sqd_elem_alu
  import sqd_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [OPC_W-1:0] SQDIFF_CODE = 4'h1
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        opsize,
  input  logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] y
);

  logic [DATA_W-1:0] width_mask;
  logic [DATA_W-1:0] a_m, b_m, diff, sq;

  always_comb begin
    width_mask = '0;
    unique case (elem_size_e'(opsize))
      SZ_B8:   width_mask[7:0]  = '1;
      SZ_B16:  width_mask[15:0] = '1;
      default: width_mask       = '1;
    endcase
  end

  always_comb begin
    a_m  = a & width_mask;
    b_m  = b & width_mask;
    diff = a_m - b_m;
    sq   = diff * diff;
    y    = (opcode == SQDIFF_CODE) ? (sq & width_mask) : a;
  end

endmodule

// File: rtl/sqd_valid_chain.sv
module sqd_valid_chain #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_bit,
  output logic [DEPTH-1:0] stage
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= 1'b0;
    else        stage[0] <= in_bit;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stage[i] <= 1'b0;
      else if (clear) stage[i] <= 1'b0;
      else            stage[i] <= stage[i-1];
    end
  end

endmodule

// File: rtl/sqd_data_chain.sv
module sqd_data_chain #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] load,
  input  logic [W-1:0]     d,
  output logic [W-1:0]     q
);

  logic [W-1:0] regs [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       regs[i] <= '0;
        else if (load[i]) regs[i] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       regs[i] <= '0;
        else if (load[i]) regs[i] <= regs[i-1];
      end
    end
  end

  assign q = regs[DEPTH-1];

endmodule

// File: rtl/sqd_lane.sv
module sqd_lane
  import sqd_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               LATENCY     = 4,
  parameter logic [OPC_W-1:0] SQDIFF_CODE = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              valid,
  input  logic [1:0]        opsize,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              we
);

  localparam int CNT_W = $clog2(LATENCY + 2);

  logic [DATA_W-1:0]  alu_y;
  logic [LATENCY-1:0] vstage;
  logic [LATENCY-1:0] load;

  sqd_elem_alu #(.DATA_W(DATA_W), .SQDIFF_CODE(SQDIFF_CODE)) u_alu (
    .a(a), .b(b), .opsize(opsize), .opcode(opcode), .y(alu_y)
  );

  sqd_valid_chain #(.DEPTH(LATENCY)) u_vchain (
    .clk(clk), .rst_n(rst_n), .clear(start), .in_bit(valid), .stage(vstage)
  );

  // A data stage moves only when a live item moves into it; a start
  // freezes the body so cancelled items never disturb the output.
  always_comb begin
    load[0] = valid;
    for (int i = 1; i < LATENCY; i++) load[i] = vstage[i-1] & ~start;
  end

  sqd_data_chain #(.DEPTH(LATENCY), .W(DATA_W)) u_dchain (
    .clk(clk), .rst_n(rst_n), .load(load), .d(alu_y), .q(result)
  );

  assign we = vstage[LATENCY-1];

  // In-flight bookkeeping used only by the checks below.
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     inflight <= '0;
    else if (start) inflight <= CNT_W'(valid);
    else            inflight <= inflight + CNT_W'(valid) - CNT_W'(we);
  end

  p_inflight_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNT_W'(LATENCY));

  p_we_needs_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (inflight != '0));

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> $stable(result));

endmodule

// File: rtl/sqd_lane_array.sv
module sqd_lane_array
  import sqd_pkg::*;
#(
  parameter int               LANES       = 4,
  parameter int               DATA_W      = 32,
  parameter int               LATENCY     = 4,
  parameter logic [OPC_W-1:0] SQDIFF_CODE = 4'h1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     valid,
  input  logic [1:0]               opsize,
  input  logic [OPC_W-1:0]         opcode,
  input  logic [LANES*DATA_W-1:0]  a_vec,
  input  logic [LANES*DATA_W-1:0]  b_vec,
  output logic [LANES*DATA_W-1:0]  res_vec,
  output logic [LANES-1:0]         wr_en
);

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    sqd_lane #(
      .DATA_W(DATA_W), .LATENCY(LATENCY), .SQDIFF_CODE(SQDIFF_CODE)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
      .opsize(opsize), .opcode(opcode),
      .a(a_vec[n*DATA_W +: DATA_W]), .b(b_vec[n*DATA_W +: DATA_W]),
      .result(res_vec[n*DATA_W +: DATA_W]), .we(wr_en[n])
    );
  end

  p_lanes_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) || (wr_en == '1));

endmodule

// File: tb/sqd_lane_array_bench.sv
module sqd_lane_array_bench;

  localparam int PERIOD = 10;
  localparam int LANES  = 4;
  localparam int DW     = 32;
  localparam int LAT    = 4;
  localparam logic [3:0] SQ = 4'h1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0;
  logic [1:0] opsize = 2'b10;
  logic [3:0] opcode = SQ;
  logic [LANES*DW-1:0] a_vec = '0, b_vec = '0;
  logic [LANES*DW-1:0] res_vec;
  logic [LANES-1:0]    wr_en;

  always #(PERIOD/2) clk = ~clk;

  sqd_lane_array #(.LANES(LANES), .DATA_W(DW), .LATENCY(LAT), .SQDIFF_CODE(SQ))
    u_sqd_lane_array (
      .clk(clk), .rst_n(rst_n), .start(start), .valid(valid),
      .opsize(opsize), .opcode(opcode), .a_vec(a_vec), .b_vec(b_vec),
      .res_vec(res_vec), .wr_en(wr_en)
    );

  typedef struct {
    logic [LANES*DW-1:0] data;
    int                  due;
    string               tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  logic [LANES*DW-1:0] last_res = '0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] model(logic [3:0] op, logic [1:0] sz,
                                          logic [DW-1:0] a, logic [DW-1:0] b);
    longint w, am, bm, d, s, m;
    if (op != SQ) return a;
    w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m  = (longint'(1) << w) - 1;
    am = longint'(a) & m;
    bm = longint'(b) & m;
    d  = am - bm;
    s  = d * d;
    return DW'(s & m);
  endfunction

  task automatic check(bit ok, string req, logic [LANES*DW-1:0] act,
                       logic [LANES*DW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic issue(bit st, logic [3:0] op, logic [1:0] sz,
                       logic [LANES*DW-1:0] a, logic [LANES*DW-1:0] b, string tag);
    exp_t e;
    @(posedge clk); #1;
    start = st; valid = 1'b1; opcode = op; opsize = sz; a_vec = a; b_vec = b;
    if (st) while (q.size() > 0 && q[$].due > cyc) void'(q.pop_back());
    for (int n = 0; n < LANES; n++)
      e.data[n*DW +: DW] = model(op, sz, a[n*DW +: DW], b[n*DW +: DW]);
    e.due = cyc + LAT;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n, bit st);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid = 1'b0; start = st && (i == 0);
      a_vec = {LANES{32'hDEAD_BEEF}}; b_vec = {LANES{32'h1234_5678}};
      if (start) while (q.size() > 0 && q[$].due > cyc) void'(q.pop_back());
    end
  endtask

  // Monitor: compares each write-back with the scoreboard head.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      exp_t f;
      check(wr_en == '0 || wr_en == '1, "R9 lanes agree",
            {{(LANES*DW-LANES){1'b0}}, wr_en}, '1);
      if (wr_en != '0) begin
        if (q.size() == 0) begin
          check(1'b0, "R6/R8 unexpected write-enable", res_vec, '0);
        end else begin
          f = q.pop_front();
          check(f.due == cyc, {"R6 timing ", f.tag}, res_vec, f.data);
          check(res_vec == f.data, f.tag, res_vec, f.data);
          last_res = res_vec;
        end
      end else begin
        if (q.size() > 0 && q[0].due <= cyc)
          check(1'b0, {"R6/R10 missing result ", q[0].tag}, res_vec, q[0].data);
        check(res_vec == last_res, "R11 hold while idle", res_vec, last_res);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LANES*DW-1:0] ra, rb;
    repeat (3) @(posedge clk);
    #1;
    check(wr_en == '0, "R7 reset write-enable", {{(LANES*DW-LANES){1'b0}}, wr_en}, '0);
    check(res_vec == '0, "R7 reset result", res_vec, '0);
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: 32-bit, B larger than A in some lanes
    issue(1'b1, SQ, 2'b10, {32'd100, 32'd7, 32'h8000_0000, 32'hFFFF_FFFF},
                           {32'd3, 32'd20, 32'h0000_0001, 32'h0000_0000}, "R1 32-bit");
    idle(LAT + 2, 1'b0);
    // R2: 8-bit with junk upper bits
    issue(1'b0, SQ, 2'b00, {32'hABCD_1203, 32'hFFFF_FF00, 32'h0000_0080, 32'h1111_11FF},
                           {32'h5555_0107, 32'h0000_00FF, 32'hFFFF_FF00, 32'h2222_2201}, "R2 8-bit");
    idle(LAT + 1, 1'b0);
    // R3: 16-bit
    issue(1'b0, SQ, 2'b01, {32'hFFFF_0003, 32'h1234_8000, 32'h0000_0100, 32'hAAAA_FFFF},
                           {32'h0000_0010, 32'h4321_0000, 32'h0000_0000, 32'h5555_0001}, "R3 16-bit");
    // R4: reserved size behaves as 32-bit, back to back with R3
    issue(1'b0, SQ, 2'b11, {32'h0001_0000, 32'd9, 32'hFFFF_FFFE, 32'h7FFF_FFFF},
                           {32'h0000_0000, 32'd12, 32'h0000_0002, 32'h0000_0001}, "R4 size 11");
    // R5: pass-through with other opcodes, several sizes
    issue(1'b0, 4'h0, 2'b00, {32'hCAFE_F00D, 32'h0102_0304, 32'hFFFF_FFFF, 32'h8000_0001},
                             {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444}, "R5 pass op0");
    issue(1'b0, 4'hF, 2'b01, {32'h0BAD_C0DE, 32'h7777_0000, 32'h0000_0001, 32'h5A5A_A5A5},
                             {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003}, "R5 pass opF");
    idle(LAT + 3, 1'b0);

    // R10: long back-to-back stream with random operands and sizes
    for (int k = 0; k < 40; k++) begin
      for (int n = 0; n < LANES; n++) begin
        ra[n*DW +: DW] = $urandom;
        rb[n*DW +: DW] = $urandom;
      end
      issue(1'b0, (k % 7 == 3) ? 4'h2 : SQ, 2'($urandom_range(0, 3)), ra, rb, "R10 stream");
    end
    idle(LAT + 3, 1'b0);

    // R8: start with an issue cancels older in-flight items
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n < LANES; n++) begin
        ra[n*DW +: DW] = $urandom;
        rb[n*DW +: DW] = $urandom;
      end
      issue(1'b0, SQ, 2'b10, ra, rb, "R8 pre-start");
    end
    issue(1'b1, SQ, 2'b10, {32'd50, 32'd40, 32'd30, 32'd20},
                           {32'd1, 32'd2, 32'd3, 32'd4}, "R8 start issue kept");
    idle(LAT + 3, 1'b0);

    // R8: start without an issue cancels everything still inside
    for (int k = 0; k < 2; k++) begin
      for (int n = 0; n < LANES; n++) begin
        ra[n*DW +: DW] = $urandom;
        rb[n*DW +: DW] = $urandom;
      end
      issue(1'b0, SQ, 2'b01, ra, rb, "R8 cancelled");
    end
    idle(LAT + 4, 1'b1);

    // R11: long idle stretch after final result
    idle(6, 1'b0);
    check(q.size() == 0, "R6 scoreboard drained", LANES*DW'(q.size()), '0);
    check(res_vec == last_res, "R11 final hold", res_vec, last_res);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule